// File: doc/BRIEF.md
# Core Regulator Power Sequencer

This block is the digital control for a core voltage regulator. It enables the PWM stage only when the upstream termination rail reports power-good and the output enable is asserted. When the ramp begins, it captures the voltage identification code. After the output reports that it is in regulation, it waits a programmed delay and then asserts power-good. It turns the output off when the enable is released or when the identification code selects the off state.

Loss of the upstream rail's power-good removes the regulator enable and power-good at once, through a combinational gate. All other control inputs pass through a two-flop synchroniser before they reach the state machine. Every delay is set in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `vr_power_seq`

## Requirements
- R1: After reset, `pwm_en` and `pgood` are 0 and `vid_hold` is 0.
- R2: `pwm_en` can rise only when the synchronised `rail_ok` and `out_en` are both 1 and `vid` is not an off code. It is never 1 while `rail_ok` is 0.
- R3: `vid_hold` takes the synchronised `vid` value on the cycle the ramp starts. It then stays unchanged while `pwm_en` is held, even if `vid` changes.
- R4: If `in_reg` is first sampled high at clock edge k while the output is enabled, `pgood` rises just after edge k+PG_CYC+2. PG_CYC is PG_DELAY_US converted to cycles and is at least 1.
- R5: `pgood` rises no later than 10 ms after the synchronised `in_reg` goes true.
- R6: `pgood` stays 1 while `in_reg` stays 1. If `in_reg` is sampled low at edge k, `pgood` is 0 just after edge k+2 while `pwm_en` stays 1, and the delay restarts.
- R7: When `rail_ok` falls, `pwm_en` and `pgood` go to 0 in the same cycle, before any clock edge.
- R8: If `out_en` is sampled low at edge k during operation, `pwm_en` and `pgood` are 0 just after edge k+2.
- R9: A `vid` value whose low five bits are all 1 is an off code, whatever bit 5 holds. If it is sampled at edge k during operation, `pwm_en` and `pgood` are 0 just after edge k+2.
- R10: After a shutdown, the output stays off while the cause persists. Once the sequencer is idle and waiting, clearing the cause at edge m brings `pwm_en` back just after edge m+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_ok | input | 1 | Upstream termination rail power-good |
| out_en | input | 1 | Output enable request |
| in_reg | input | 1 | Output-in-regulation comparator flag |
| vid | input | VID_W | Voltage identification code |
| pwm_en | output | 1 | Enable to the PWM stage |
| pgood | output | 1 | Active-high power-good |
| vid_hold | output | VID_W | Code captured at ramp start |

## Verification
Synchronised inputs reach the state after their third rising edge. The bench therefore drives each input on a falling edge, counts the rising edges, and samples 1 ns after the edge at which a result is due, having first confirmed the old value one edge earlier. `pgood` is checked on both sides of edge k+PG_CYC+2. The `rail_ok` gate is checked 1 ns after the input falls, with no edge in between. The table of steady-state vectors waits well past every latency before comparing.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_WAIT     = 3'd1,
    ST_RAMP     = 3'd2,
    ST_PGDLY    = 3'd3,
    ST_ON       = 3'd4,
    ST_SHUTDOWN = 3'd5
  } seq_state_t;

  // microseconds to clock cycles, never below one cycle
  function automatic longint unsigned us_to_cyc(input longint unsigned clk_hz,
                                                input longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1000000;
    return (c == 0) ? 64'd1 : c;
  endfunction

  // off code: low five identification bits all high, top bit ignored
  function automatic logic is_off_code(input logic [5:0] code);
    return &code[4:0];
  endfunction

endpackage

// File: rtl/vr_sync2.sv
module vr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vr_seq_timer.sv
module vr_seq_timer #(
  parameter longint unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vr_seq_fsm.sv
module vr_seq_fsm
  import vr_seq_pkg::*;
#(
  parameter int VID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_s,
  input  logic             oen_s,
  input  logic             inreg_s,
  input  logic [VID_W-1:0] vid_s,
  input  logic             dly_done,
  output seq_state_t       state,
  output logic             en_state,
  output logic             pg_state,
  output logic             dly_run,
  output logic [VID_W-1:0] vid_hold
);
  seq_state_t nxt;
  logic       off_req;
  logic       start_ramp;

  assign off_req    = !oen_s || is_off_code(6'(vid_s));
  assign start_ramp = (state == ST_WAIT) && qual_s && !off_req;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:      if (qual_s) nxt = ST_WAIT;
      ST_WAIT:     if (!qual_s) nxt = ST_OFF;
                   else if (!off_req) nxt = ST_RAMP;
      ST_RAMP:     if (!qual_s) nxt = ST_OFF;
                   else if (off_req) nxt = ST_SHUTDOWN;
                   else if (inreg_s) nxt = ST_PGDLY;
      ST_PGDLY:    if (!qual_s) nxt = ST_OFF;
                   else if (off_req) nxt = ST_SHUTDOWN;
                   else if (!inreg_s) nxt = ST_RAMP;
                   else if (dly_done) nxt = ST_ON;
      ST_ON:       if (!qual_s) nxt = ST_OFF;
                   else if (off_req) nxt = ST_SHUTDOWN;
                   else if (!inreg_s) nxt = ST_RAMP;
      ST_SHUTDOWN: nxt = ST_OFF;
      default:     nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      vid_hold <= '0;
    end else begin
      state <= nxt;
      if (start_ramp) vid_hold <= vid_s;
    end
  end

  assign en_state = (state == ST_RAMP) || (state == ST_PGDLY) || (state == ST_ON);
  assign pg_state = (state == ST_ON);
  assign dly_run  = (state == ST_PGDLY);
endmodule

// File: rtl/vr_power_seq.sv
module vr_power_seq
  import vr_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100000000,
  parameter longint unsigned PG_DELAY_US = 1000,
  parameter int              VID_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rail_ok,
  input  logic             out_en,
  input  logic             in_reg,
  input  logic [VID_W-1:0] vid,
  output logic             pwm_en,
  output logic             pgood,
  output logic [VID_W-1:0] vid_hold
);
  localparam longint unsigned PG_CYC = us_to_cyc(CLK_HZ, PG_DELAY_US);
  localparam int SW = VID_W + 3;

  logic [SW-1:0] raw_bus, sync_bus;
  logic             qual_s, oen_s, inreg_s;
  logic [VID_W-1:0] vid_s;
  seq_state_t       state;
  logic             en_state, pg_state, dly_run, dly_done;

  assign raw_bus = {vid, in_reg, out_en, rail_ok};

  vr_sync2 #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign qual_s  = sync_bus[0];
  assign oen_s   = sync_bus[1];
  assign inreg_s = sync_bus[2];
  assign vid_s   = sync_bus[SW-1:3];

  vr_seq_timer #(.LIMIT(PG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(dly_run), .done(dly_done)
  );

  vr_seq_fsm #(.VID_W(VID_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .qual_s(qual_s), .oen_s(oen_s),
    .inreg_s(inreg_s), .vid_s(vid_s), .dly_done(dly_done),
    .state(state), .en_state(en_state), .pg_state(pg_state),
    .dly_run(dly_run), .vid_hold(vid_hold)
  );

  // rail loss removes both outputs without waiting for the synchroniser
  assign pwm_en = en_state && rail_ok;
  assign pgood  = pg_state && rail_ok;
endmodule

// File: rtl/vr_power_seq_chk.sv
module vr_power_seq_chk
  import vr_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100000000,
  parameter int              VID_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rail_ok,
  input logic             qual_s,
  input logic             oen_s,
  input logic             inreg_s,
  input logic [VID_W-1:0] vid_s,
  input seq_state_t       state,
  input logic             en_state,
  input logic             pg_state,
  input logic             pwm_en,
  input logic             pgood,
  input logic [VID_W-1:0] vid_hold
);
  localparam longint unsigned BOUND_CYC = us_to_cyc(CLK_HZ, 10000);

  logic [63:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (inreg_s && en_state && !pg_state) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= '0;
  end

  p_en_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_state) |-> $past(qual_s && oen_s && !is_off_code(6'(vid_s))));

  p_en_rail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> rail_ok);

  p_vid_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_state && $past(en_state) |-> $stable(vid_hold));

  p_pg_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= BOUND_CYC);

  p_pg_inreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_state && $past(pg_state) |-> $past(inreg_s));

  p_pg_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> pwm_en);

  p_rail_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_state && !qual_s |=> !en_state);

  p_oen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_state && qual_s && !oen_s |=> state == ST_SHUTDOWN);

  p_sd_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SHUTDOWN |=> state == ST_OFF);
endmodule

bind vr_power_seq vr_power_seq_chk #(.CLK_HZ(CLK_HZ), .VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .qual_s(qual_s),
  .oen_s(oen_s), .inreg_s(inreg_s), .vid_s(vid_s), .state(state),
  .en_state(en_state), .pg_state(pg_state), .pwm_en(pwm_en),
  .pgood(pgood), .vid_hold(vid_hold)
);

// File: tb/vr_power_seq_tb.sv
module vr_power_seq_tb;
  localparam int PG_US  = 1;
  localparam int PG_CYC = 100;  // 1 us at 100 MHz
  localparam int SETTLE = PG_CYC + 20;

  logic clk = 0;
  logic rst_n = 0;
  logic rail_ok = 0, out_en = 0, in_reg = 0;
  logic [5:0] vid = 6'h10;
  logic pwm_en, pgood;
  logic [5:0] vid_hold;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vr_power_seq #(.CLK_HZ(100000000), .PG_DELAY_US(PG_US), .VID_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .out_en(out_en),
    .in_reg(in_reg), .vid(vid), .pwm_en(pwm_en), .pgood(pgood),
    .vid_hold(vid_hold)
  );

  // fields: rail, oen, vid[5:0], inreg | exp en, exp pg, exp vid_hold[5:0]
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,6'h10,1'b0, 1'b0,1'b0,6'h00},
    {1'b1,1'b0,6'h10,1'b0, 1'b0,1'b0,6'h00},
    {1'b1,1'b1,6'h10,1'b0, 1'b1,1'b0,6'h10},
    {1'b1,1'b1,6'h10,1'b1, 1'b1,1'b1,6'h10},
    {1'b1,1'b1,6'h1F,1'b1, 1'b0,1'b0,6'h10},
    {1'b1,1'b1,6'h3F,1'b1, 1'b0,1'b0,6'h10},
    {1'b1,1'b1,6'h20,1'b1, 1'b1,1'b1,6'h20},
    {1'b1,1'b0,6'h20,1'b1, 1'b0,1'b0,6'h20},
    {1'b0,1'b1,6'h20,1'b1, 1'b0,1'b0,6'h20},
    {1'b1,1'b1,6'h05,1'b0, 1'b1,1'b0,6'h05},
    {1'b1,1'b1,6'h05,1'b1, 1'b1,1'b1,6'h05}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    chk("R1 en", {7'd0, pwm_en}, 8'd0);
    chk("R1 pg", {7'd0, pgood}, 8'd0);
    chk("R1 vid", {2'd0, vid_hold}, 8'd0);
    @(negedge clk) rst_n = 1;

    // table walk: steady-state results (R2, R3, R4, R8, R9, R7)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rail_ok, out_en, vid, in_reg} = VEC[i][16:8];
      edges(SETTLE);
      chk($sformatf("R2 vec%0d en", i), {7'd0, pwm_en}, {7'd0, VEC[i][7]});
      chk($sformatf("R6 vec%0d pg", i), {7'd0, pgood}, {7'd0, VEC[i][6]});
      if (VEC[i][7]) chk($sformatf("R3 vec%0d vid", i), {2'd0, vid_hold}, {2'd0, VEC[i][5:0]});
    end

    // R3: change vid while on, hold unchanged
    @(negedge clk) vid = 6'h07;
    edges(10);
    chk("R3 hold", {2'd0, vid_hold}, 8'h05);
    chk("R3 en", {7'd0, pwm_en}, 8'd1);

    // R6: in_reg falls, pg low after edge k+2
    @(negedge clk) in_reg = 0;
    edges(2);
    chk("R6 pg before", {7'd0, pgood}, 8'd1);
    edges(1);
    chk("R6 pg after", {7'd0, pgood}, 8'd0);
    chk("R6 en kept", {7'd0, pwm_en}, 8'd1);

    // R4: exact power-good delay
    edges(5);
    @(negedge clk) in_reg = 1;
    edges(PG_CYC + 2);
    chk("R4 pg before", {7'd0, pgood}, 8'd0);
    edges(1);
    chk("R4 pg at", {7'd0, pgood}, 8'd1);
    chk("R5 pg within bound", {7'd0, pgood}, 8'd1);

    // R7: rail loss removes outputs at once
    @(negedge clk) rail_ok = 0;
    #1;
    chk("R7 en", {7'd0, pwm_en}, 8'd0);
    chk("R7 pg", {7'd0, pgood}, 8'd0);
    edges(5);
    @(negedge clk) rail_ok = 1;
    edges(SETTLE + 10);
    chk("R2 back on", {7'd0, pgood}, 8'd1);

    // R8: out_en low, off after edge k+2
    @(negedge clk) out_en = 0;
    edges(2);
    chk("R8 en before", {7'd0, pwm_en}, 8'd1);
    edges(1);
    chk("R8 en after", {7'd0, pwm_en}, 8'd0);
    chk("R8 pg after", {7'd0, pgood}, 8'd0);

    // R10: stays off while cause holds, then re-enables at m+2
    edges(10);
    chk("R10 held off", {7'd0, pwm_en}, 8'd0);
    @(negedge clk) out_en = 1;
    edges(2);
    chk("R10 en before", {7'd0, pwm_en}, 8'd0);
    edges(1);
    chk("R10 en after", {7'd0, pwm_en}, 8'd1);
    edges(SETTLE);

    // R9: off code with bit 5 set
    @(negedge clk) vid = 6'h3F;
    edges(2);
    chk("R9 en before", {7'd0, pwm_en}, 8'd1);
    edges(1);
    chk("R9 en after", {7'd0, pwm_en}, 8'd0);
    edges(10);
    chk("R10 off code held", {7'd0, pwm_en}, 8'd0);
    @(negedge clk) vid = 6'h0A;
    edges(2);
    chk("R10 vid before", {7'd0, pwm_en}, 8'd0);
    edges(1);
    chk("R10 vid after", {7'd0, pwm_en}, 8'd1);
    chk("R3 new capture", {2'd0, vid_hold}, 8'h0A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule